// File: doc/BRIEF.md
# SDRAM Read Burst Datapath

This block models the device side of a pipelined SDRAM read path. Every clock it takes either a READ (with a bank and a starting column) or a NOP. After a programmable CAS latency it drives a data word with an output-enable. It keeps driving one word per clock until the burst completes. A fixed burst ends after its length. A full-page burst runs until a newer READ replaces it. The storage is a small flop array per bank. A bench or an enclosing model fills it through a direct load port. Row activation, precharge, refresh, writes and analog output timing are not modelled.

Each accepted READ moves through a latency shift register and is tapped at the stage that matches the CAS latency. When it leaves the tap it takes over the burst controller at once, whatever burst is running. This lets READs arrive on every clock, to the same bank or to different banks. A new burst can start on the clock right after the last wanted word of the old one, so the bus has no idle gap. The controller state machine has three states. ST_IDLE means the bus is released. ST_FIXED means a fixed-length burst is running and counting its remaining words. ST_PAGE means a full-page burst is running and never ends by itself. The transitions are:
- start: a tapped READ moves any state to ST_FIXED, to ST_PAGE, or to ST_IDLE for length 1.
- finish: ST_FIXED moves to ST_IDLE after the last counted word.
- hold: ST_IDLE and ST_PAGE stay where they are when no READ is tapped.

Top module: `sdr_rdpath`

## Requirements
- R1: While reset is asserted, and before any READ has emerged, `dq_oe` is 0 and `dq_out` is 0.
- R2: `cfg_cl` codes 1, 2 and 3 select a CAS latency of 1, 2 or 3 clocks. Code 0 behaves as 3. A READ registered at edge k puts its first word on `dq_out`, with `dq_oe` high, from edge k+CL-1, so the word is valid at edge k+CL.
- R3: A fixed burst drives exactly its length in words on consecutive clocks. It then drops `dq_oe` if no newer READ has emerged.
- R4: Within a fixed burst of length L, the column advances by one and wraps inside the aligned block of L columns that holds the start column. For example, a start at column 6 with L=4 reads 6, 7, 4, 5.
- R5: A full-page burst advances the column by one each clock, wraps from the last column of the page to column 0, and keeps `dq_oe` high until a newer READ takes over.
- R6: A READ that emerges while a burst runs truncates it. Its first word follows the last delivered word of the old burst on the next clock, and no old word appears after that.
- R7: A READ is accepted on every clock, whether it targets the same bank or a different one, and each READ delivers its first word at full rate.
- R8: A READ issued CL-1 clocks before the edge at which the last word of a completing fixed burst is valid delivers its first word on the very next clock, with no idle cycle.
- R9: While `dq_oe` is 0, `dq_out` is 0. NOP cycles, with any bank or column on the command inputs, start nothing.
- R10: `cfg_bl` codes 0, 1, 2 and 3 select fixed lengths of 1, 2, 4 and 8. Any code with bit 2 set selects full page. The length is taken when the burst starts.
- R11: A word written through the load port is returned by a later READ of that bank and column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_read | input | 1 | 1 = READ, 0 = NOP for this clock |
| cmd_bank | input | BW | Bank of the READ |
| cmd_col | input | CW | Starting column of the READ |
| cfg_cl | input | 2 | CAS latency code (R2) |
| cfg_bl | input | 3 | Burst length code (R10) |
| ld_en | input | 1 | Direct array write strobe |
| ld_bank | input | BW | Bank written by the load port |
| ld_col | input | CW | Column written by the load port |
| ld_data | input | DW | Word written by the load port |
| dq_out | output | DW | Read data; 0 while not enabled |
| dq_oe | output | 1 | Output-enable of the data bus |

## Verification
Single READs are issued under each CAS latency. They show whether the first word lands on the right clock and whether the bus releases after the burst. Start columns inside and at the edge of aligned blocks, together with every length code, separate sequential block wrap from plain increment. A full-page run across the page end separates wrapping from stopping. Overlapping READs, one-per-clock streams to the same and to alternating banks, and READs issued exactly CL-1 ahead of a burst end tell truncation, full-rate acceptance and seamless chaining apart from gaps or stale words. A rewritten array word then shows the load path feeding the read path.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } burst_st_e;

    // Fixed burst length in words for the two low bits of the length code.
    function automatic logic [3:0] bl_len(input logic [1:0] code);
        logic [3:0] n;
        unique case (code)
            2'd0:    n = 4'd1;
            2'd1:    n = 4'd2;
            2'd2:    n = 4'd4;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sdr_rd_latpipe.sv
module sdr_rd_latpipe #(
    parameter int BW = 2,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_read,
    input  logic [BW-1:0] cmd_bank,
    input  logic [CW-1:0] cmd_col,
    input  logic [1:0]    cfg_cl,
    output logic          st_valid,
    output logic [BW-1:0] st_bank,
    output logic [CW-1:0] st_col
);
    localparam int MAX_CL = 3;
    localparam int DEPTH  = MAX_CL - 1;

    logic [DEPTH-1:0]         v_q;
    logic [DEPTH-1:0][BW-1:0] b_q;
    logic [DEPTH-1:0][CW-1:0] c_q;
    logic [1:0]               cl_eff;

    assign cl_eff = (cfg_cl == 2'd0) ? 2'd3 : cfg_cl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q[0] <= cmd_read;
            for (int i = 1; i < DEPTH; i++) begin
                v_q[i] <= v_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        b_q[0] <= cmd_bank;
        c_q[0] <= cmd_col;
        for (int i = 1; i < DEPTH; i++) begin
            b_q[i] <= b_q[i-1];
            c_q[i] <= c_q[i-1];
        end
    end

    // Tap 0 is the live command (latency 1), tap i is stage i-1.
    always_comb begin
        st_valid = cmd_read;
        st_bank  = cmd_bank;
        st_col   = cmd_col;
        for (int i = 1; i < MAX_CL; i++) begin
            if (int'(cl_eff) == i + 1) begin
                st_valid = v_q[i-1];
                st_bank  = b_q[i-1];
                st_col   = c_q[i-1];
            end
        end
    end

endmodule

// File: rtl/sdr_rd_bankarray.sv
module sdr_rd_bankarray #(
    parameter int BANKS = 4,
    parameter int COLS  = 16,
    parameter int DW    = 16,
    parameter int BW    = 2,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [BW-1:0] ld_bank,
    input  logic [CW-1:0] ld_col,
    input  logic [DW-1:0] ld_data,
    input  logic [BW-1:0] rd_bank,
    input  logic [CW-1:0] rd_col,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [COLS];

        always_ff @(posedge clk) begin
            if (ld_en && (ld_bank == BW'(b))) begin
                mem[ld_col] <= ld_data;
            end
        end

        assign bank_rd[b] = mem[rd_col];
    end

    assign rd_data = bank_rd[rd_bank];

endmodule

// File: rtl/sdr_rd_burstctl.sv
module sdr_rd_burstctl
    import sdr_rd_pkg::*;
#(
    parameter int BW = 2,
    parameter int CW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [BW-1:0] st_bank,
    input  logic [CW-1:0] st_col,
    input  logic [2:0]    cfg_bl,
    input  logic [DW-1:0] rd_data,
    output logic [BW-1:0] rd_bank,
    output logic [CW-1:0] rd_col,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    burst_st_e     state_q, state_d;
    logic [BW-1:0] bank_q, bank_d;
    logic [CW-1:0] col_q, col_d;
    logic [CW-1:0] mask_q, mask_d;
    logic [3:0]    left_q, left_d;
    logic          emit;
    logic [3:0]    len_new;

    // Next column: bits outside the mask hold, bits inside count and wrap.
    function automatic logic [CW-1:0] step(input logic [CW-1:0] c,
                                           input logic [CW-1:0] m);
        return (c & ~m) | ((c + CW'(1)) & m);
    endfunction

    assign len_new = bl_len(cfg_bl[1:0]);

    always_comb begin
        state_d = state_q;
        bank_d  = bank_q;
        col_d   = col_q;
        mask_d  = mask_q;
        left_d  = left_q;
        emit    = 1'b0;
        rd_bank = bank_q;
        rd_col  = col_q;
        if (st_valid) begin
            emit    = 1'b1;
            rd_bank = st_bank;
            rd_col  = st_col;
            bank_d  = st_bank;
            left_d  = len_new - 4'd1;
            if (cfg_bl[2]) begin
                mask_d  = '1;
                state_d = ST_PAGE;
            end else begin
                mask_d  = CW'(len_new - 4'd1);
                state_d = (len_new == 4'd1) ? ST_IDLE : ST_FIXED;
            end
            col_d = step(st_col, mask_d);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FIXED: begin
                    emit   = 1'b1;
                    col_d  = step(col_q, mask_q);
                    left_d = left_q - 4'd1;
                    if (left_q == 4'd1) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_PAGE: begin
                    emit  = 1'b1;
                    col_d = step(col_q, mask_q);
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bank_q  <= '0;
            col_q   <= '0;
            mask_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            bank_q  <= bank_d;
            col_q   <= col_d;
            mask_q  <= mask_d;
            left_q  <= left_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            dq_oe  <= emit;
            dq_out <= emit ? rd_data : '0;
        end
    end

endmodule

// File: rtl/sdr_rdpath.sv
module sdr_rdpath #(
    parameter int BANKS = 4,
    parameter int COLS  = 16,
    parameter int DW    = 16,
    localparam int BW   = $clog2(BANKS),
    localparam int CW   = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_read,
    input  logic [BW-1:0] cmd_bank,
    input  logic [CW-1:0] cmd_col,
    input  logic [1:0]    cfg_cl,
    input  logic [2:0]    cfg_bl,
    input  logic          ld_en,
    input  logic [BW-1:0] ld_bank,
    input  logic [CW-1:0] ld_col,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    logic          st_valid;
    logic [BW-1:0] st_bank;
    logic [CW-1:0] st_col;
    logic [BW-1:0] rd_bank;
    logic [CW-1:0] rd_col;
    logic [DW-1:0] rd_data;

    sdr_rd_latpipe #(.BW(BW), .CW(CW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_read (cmd_read),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .cfg_cl   (cfg_cl),
        .st_valid (st_valid),
        .st_bank  (st_bank),
        .st_col   (st_col)
    );

    sdr_rd_bankarray #(.BANKS(BANKS), .COLS(COLS), .DW(DW), .BW(BW), .CW(CW)) u_array (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_bank (ld_bank),
        .ld_col  (ld_col),
        .ld_data (ld_data),
        .rd_bank (rd_bank),
        .rd_col  (rd_col),
        .rd_data (rd_data)
    );

    sdr_rd_burstctl #(.BW(BW), .CW(CW), .DW(DW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_bank  (st_bank),
        .st_col   (st_col),
        .cfg_bl   (cfg_bl),
        .rd_data  (rd_data),
        .rd_bank  (rd_bank),
        .rd_col   (rd_col),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/sdr_rdpath_chk.sv
module sdr_rdpath_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_read,
    input logic [1:0]    cfg_cl,
    input logic [2:0]    cfg_bl,
    input logic [DW-1:0] dq_out,
    input logic          dq_oe
);
    // R9: a released bus carries zero
    a_r9_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_out == '0));

    // R2: latency 1 and 2 place the first word on the bus in time
    a_r2_cl1_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cl == 2'd1) |=> dq_oe);

    a_r2_cl2_first: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cl == 2'd2) |=> ##1 dq_oe);

    // R3: a single-word burst with nothing behind it releases the bus
    a_r3_single_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read && cfg_cl == 2'd1 && cfg_bl == 3'd0) ##1 !cmd_read |=> !dq_oe);

    // R5: a full-page burst never ends on its own
    a_r5_page_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && cfg_bl[2] && $past(cfg_bl[2])) |=> dq_oe);

    // R6: a READ landing on a running burst leaves no gap (latency 1)
    a_r6_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && cmd_read && cfg_cl == 2'd1) |=> $stable(dq_oe));

endmodule

bind sdr_rdpath sdr_rdpath_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_read (cmd_read),
    .cfg_cl   (cfg_cl),
    .cfg_bl   (cfg_bl),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/sdr_rdpath_tb_top.sv
`timescale 1ns/1ps
module sdr_rdpath_tb_top;
    localparam int BANKS = 4;
    localparam int COLS  = 16;
    localparam int DW    = 16;
    localparam int BW    = 2;
    localparam int CW    = 4;
    localparam int HZN   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_read = 1'b0;
    logic [BW-1:0] cmd_bank = '0;
    logic [CW-1:0] cmd_col = '0;
    logic [1:0]    cfg_cl = 2'd1;
    logic [2:0]    cfg_bl = 3'd0;
    logic          ld_en = 1'b0;
    logic [BW-1:0] ld_bank = '0;
    logic [CW-1:0] ld_col = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    always #2 clk = ~clk;

    sdr_rdpath #(.BANKS(BANKS), .COLS(COLS), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .ld_en(ld_en),
        .ld_bank(ld_bank), .ld_col(ld_col), .ld_data(ld_data),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [DW-1:0] ref_mem [BANKS][COLS];
    bit            exp_oe [HZN];
    logic [DW-1:0] exp_dq [HZN];
    bit            c_v [HZN];
    int            c_b [HZN];
    int            c_c [HZN];
    int            cur_cl;
    int            cur_bl;

    function automatic void clear_plan();
        for (int t = 0; t < HZN; t++) begin
            exp_oe[t] = 1'b0; exp_dq[t] = '0;
            c_v[t] = 1'b0; c_b[t] = 0; c_c[t] = 0;
        end
    endfunction

    // Expected bus from R2/R3/R4/R5/R6/R10: READ at edge k fills from k+CL-1 on.
    function automatic void plan_read(int k, int b, int c);
        int start, len, col, cl;
        bit page;
        c_v[k] = 1'b1; c_b[k] = b; c_c[k] = c;
        cl    = (cur_cl == 0) ? 3 : cur_cl;
        start = k + cl - 1;
        page  = (cur_bl >= 4);
        len   = page ? HZN : (1 << (cur_bl % 4));
        for (int t = start; t < HZN; t++) begin
            int i;
            i = t - start;
            if (i < len) begin
                if (page) col = (c + i) % COLS;
                else      col = (c / len) * len + ((c + i) % len);
                exp_oe[t] = 1'b1;
                exp_dq[t] = ref_mem[b][col];
            end else begin
                exp_oe[t] = 1'b0;
                exp_dq[t] = '0;
            end
        end
    endfunction

    task automatic check_cycle(string tag, int t);
        n_vec++;
        // R9: with the bus released the data must be zero
        if (dq_oe !== exp_oe[t] || dq_out !== exp_dq[t]) begin
            n_bad++;
            $display("FAIL %s cycle %0d: oe=%0b dq=%h expected oe=%0b dq=%h",
                     tag, t, dq_oe, dq_out, exp_oe[t], exp_dq[t]);
        end
    endtask

    task automatic run_plan(string tag, int ncyc);
        @(negedge clk);
        rst_n = 1'b0; cmd_read = 1'b0;
        cfg_cl = 2'(cur_cl); cfg_bl = 3'(cur_bl);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            cmd_read = c_v[t];
            // NOP cycles carry junk addresses that must be ignored (R9)
            cmd_bank = c_v[t] ? BW'(c_b[t]) : BW'(t * 3 + 1);
            cmd_col  = c_v[t] ? CW'(c_c[t]) : CW'(t * 5 + 2);
            @(negedge clk);
            check_cycle(tag, t);
        end
        cmd_read = 1'b0;
    endtask

    task automatic load_word(int b, int c, logic [DW-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_bank = BW'(b); ld_col = CW'(c); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        ref_mem[b][c] = d;
    endtask

    task automatic t_reset();
        // R1
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        n_vec++;
        if (dq_oe !== 1'b0 || dq_out !== '0) begin
            n_bad++;
            $display("FAIL R1 reset: oe=%0b dq=%h expected oe=0 dq=0", dq_oe, dq_out);
        end
        cur_cl = 2; cur_bl = 2; clear_plan();
        run_plan("R1 idle after reset", 6);
    endtask

    task automatic t_latency();
        // R2 and R3: one length-4 burst under each latency code, code 0 as 3
        for (int cl = 0; cl < 4; cl++) begin
            cur_cl = cl; cur_bl = 2; clear_plan();
            plan_read(2, 1, 4);
            run_plan($sformatf("R2/R3 cl code %0d", cl), 14);
        end
    endtask

    task automatic t_wrap();
        // R4 and R10: block wrap for each fixed length
        cur_cl = 2; cur_bl = 2; clear_plan(); plan_read(0, 0, 6);
        run_plan("R4 len4 col6", 10);
        cur_cl = 1; cur_bl = 3; clear_plan(); plan_read(1, 3, 13);
        run_plan("R4 len8 col13", 14);
        cur_cl = 3; cur_bl = 1; clear_plan(); plan_read(0, 2, 3);
        run_plan("R10 len2 col3", 8);
        cur_cl = 2; cur_bl = 0; clear_plan(); plan_read(0, 1, 9);
        run_plan("R10 len1 col9", 6);
    endtask

    task automatic t_page();
        // R5: page wraps from 15 to 0 and keeps going; R10: code 4 is page too
        cur_cl = 3; cur_bl = 7; clear_plan(); plan_read(1, 2, 13);
        run_plan("R5 page wrap", 40);
        cur_cl = 1; cur_bl = 4; clear_plan(); plan_read(0, 0, 15);
        run_plan("R10 page alias", 24);
    endtask

    task automatic t_trunc();
        // R6: truncation across banks and within one page
        cur_cl = 2; cur_bl = 3; clear_plan();
        plan_read(0, 0, 0); plan_read(3, 1, 5);
        run_plan("R6 len8 cut by other bank", 16);
        cur_cl = 3; cur_bl = 7; clear_plan();
        plan_read(0, 2, 10); plan_read(6, 2, 2);
        run_plan("R6 page cut same bank", 20);
    endtask

    task automatic t_b2b();
        // R7: a READ every clock, same and alternating banks
        cur_cl = 3; cur_bl = 2; clear_plan();
        for (int k = 2; k < 10; k++) plan_read(k, (k < 6) ? 1 : k % 4, (k * 7) % COLS);
        run_plan("R7 one per clock", 20);
    endtask

    task automatic t_seam();
        // R8: chained bursts with no idle cycle
        cur_cl = 2; cur_bl = 2; clear_plan();
        plan_read(0, 1, 0); plan_read(4, 2, 8); plan_read(8, 1, 12);
        run_plan("R8 chained len4", 16);
        cur_cl = 3; cur_bl = 1; clear_plan();
        plan_read(0, 3, 1); plan_read(2, 0, 7);
        run_plan("R8 chained len2", 10);
    endtask

    task automatic t_load();
        // R11: a rewritten word is read back
        load_word(3, 7, 16'hBEEF);
        load_word(3, 4, 16'h1234);
        cur_cl = 1; cur_bl = 2; clear_plan(); plan_read(1, 3, 6);
        run_plan("R11 load then read", 8);
    endtask

    initial begin
        for (int b = 0; b < BANKS; b++)
            for (int c = 0; c < COLS; c++) begin
                ld_en = 1'b1; ld_bank = BW'(b); ld_col = CW'(c);
                ld_data = {4'(b), 4'(c), 8'(c * 7 + b * 3 + 1)};
                ref_mem[b][c] = ld_data;
                @(negedge clk);
            end
        ld_en = 1'b0;
        t_reset();
        t_latency();
        t_wrap();
        t_page();
        t_trunc();
        t_b2b();
        t_seam();
        t_load();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule